// File: doc/BRIEF.md
# Rotating Register File Mapper

This block is a multi-ported register file whose upper part is renamed by a moving offset. It serves software-pipelined loops. A loop-closing instruction pulses a rotate strobe once per iteration. The same logical register name then selects a different physical entry on each iteration, so one instruction stream can keep several iterations in flight without unrolling.

Specifiers below a fixed boundary (32 by default) address the file directly. Specifiers from the boundary to the top of the file (96 entries by default) have the current base added to their offset inside the region, wrapping modulo the region size. The base moves down by one on each rotate strobe. As a result, a value produced under name s appears k iterations later under name s+k. Two asynchronous read ports and one synchronous write port share the mapping. A clear strobe returns the base to zero, and the base value is driven out for observation.

Top module: `rrf_rotating_file`

## Requirements
- R1: After reset the base output is 0 and every register reads as 0.
- R2: A specifier below 32 selects physical entry equal to the specifier, whatever the base.
- R3: A specifier s of 32 or more selects physical entry 32 + ((s - 32 + base) mod 96), for both reads and writes.
- R4: A rotate strobe without clear lowers the base by one at the next clock edge, and 0 wraps to 95. The base is always below 96.
- R5: A value written under rotating specifier s reads back under specifier s+k after k rotations. Specifier 127 continues at 32.
- R6: A write in the same cycle as a rotate strobe uses the base held before that edge.
- R7: A clear strobe sets the base to 0 at the next edge and takes priority over a simultaneous rotate strobe.
- R8: With write enable low, no register changes, whatever the write index and data.
- R9: Both read ports are combinational and independent. A read of the entry being written returns the old value until the clock edge.
- R10: Without a rotate or clear strobe, the base holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd0_idx_i | input | 7 | Read port 0 logical specifier |
| rd0_data_o | output | 64 | Read port 0 data |
| rd1_idx_i | input | 7 | Read port 1 logical specifier |
| rd1_data_o | output | 64 | Read port 1 data |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 7 | Write logical specifier |
| wr_data_i | input | 64 | Write data |
| rot_i | input | 1 | Rotate strobe, lowers the base by one |
| base_clr_i | input | 1 | Clears the base to zero |
| base_o | output | 7 | Current rotating base |

## Verification
The bench targets the base wrap from 0 to 95. A design that wrapped to 127, or that let the base escape the region, would scatter rotating accesses into the direct region. It checks the specifier wrap from 127 back to 32, which a plain add without region modulo would send to the wrong entry, and the direct region under a non-zero base, which a mapper that offset every specifier would corrupt. It also checks a write coinciding with a rotate, which lands one entry off if the new base is used. Clear against rotate priority is checked as well, together with read-during-write ordering, which a bypassing design would break by returning the new value early.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int unsigned RRF_NREG   = 128;
  localparam int unsigned RRF_WIDTH  = 64;
  localparam int unsigned RRF_ROT_LO = 32;
  localparam int unsigned RRF_RD_PORTS = 2;
endpackage

// File: rtl/rrf_map.sv
module rrf_map #(
  parameter int unsigned NREG   = 128,
  parameter int unsigned ROT_LO = 32,
  localparam int unsigned ROT_N = NREG - ROT_LO,
  localparam int unsigned IDX_W = $clog2(NREG),
  localparam int unsigned BASE_W = $clog2(ROT_N),
  localparam int unsigned SUM_W = $clog2(2 * ROT_N)
) (
  input  logic [IDX_W-1:0]  log_i,
  input  logic [BASE_W-1:0] base_i,
  output logic [IDX_W-1:0]  phys_o
);
  logic [SUM_W-1:0] off_w, sum_w, wrap_w;
  logic [SUM_W:0]   abs_w;

  always_comb begin
    off_w  = SUM_W'(log_i) - SUM_W'(ROT_LO);
    sum_w  = off_w + SUM_W'(base_i);
    // both operands below ROT_N, so one subtract is a full modulo
    wrap_w = (sum_w >= SUM_W'(ROT_N)) ? sum_w - SUM_W'(ROT_N) : sum_w;
    abs_w  = (SUM_W+1)'(wrap_w) + (SUM_W+1)'(ROT_LO);
    phys_o = (log_i < IDX_W'(ROT_LO)) ? log_i : abs_w[IDX_W-1:0];
  end
endmodule

// File: rtl/rrf_base.sv
module rrf_base #(
  parameter int unsigned ROT_N = 96,
  localparam int unsigned BASE_W = $clog2(ROT_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rot_i,
  input  logic              clr_i,
  output logic [BASE_W-1:0] base_o
);
  logic [BASE_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      base_q <= '0;
    else if (clr_i)   base_q <= '0;
    else if (rot_i)   base_q <= (base_q == '0) ? BASE_W'(ROT_N - 1) : base_q - 1'b1;
  end

  assign base_o = base_q;
endmodule

// File: rtl/rrf_store.sv
module rrf_store #(
  parameter int unsigned NREG  = 128,
  parameter int unsigned WIDTH = 64,
  parameter int unsigned NRD   = 2,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NRD-1:0][IDX_W-1:0]  rd_idx_i,
  output logic [NRD-1:0][WIDTH-1:0]  rd_data_o,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [WIDTH-1:0]           wr_data_i
);
  logic [WIDTH-1:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NREG); i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
    assign rd_data_o[p] = mem_q[rd_idx_i[p]];
  end
endmodule

// File: rtl/rrf_rotating_file.sv
module rrf_rotating_file
  import rrf_pkg::*;
#(
  parameter int unsigned NREG   = RRF_NREG,
  parameter int unsigned WIDTH  = RRF_WIDTH,
  parameter int unsigned ROT_LO = RRF_ROT_LO,
  localparam int unsigned ROT_N  = NREG - ROT_LO,
  localparam int unsigned IDX_W  = $clog2(NREG),
  localparam int unsigned BASE_W = $clog2(ROT_N),
  localparam int unsigned NRD    = RRF_RD_PORTS,
  localparam int unsigned NMAP   = NRD + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd0_idx_i,
  output logic [WIDTH-1:0]  rd0_data_o,
  input  logic [IDX_W-1:0]  rd1_idx_i,
  output logic [WIDTH-1:0]  rd1_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  input  logic              rot_i,
  input  logic              base_clr_i,
  output logic [BASE_W-1:0] base_o
);
  logic [BASE_W-1:0]              base_w;
  logic [NMAP-1:0][IDX_W-1:0]     log_w, phys_w;
  logic [NRD-1:0][IDX_W-1:0]      rd_phys_w;
  logic [NRD-1:0][WIDTH-1:0]      rd_data_w;

  rrf_base #(.ROT_N(ROT_N)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rot_i  (rot_i),
    .clr_i  (base_clr_i),
    .base_o (base_w)
  );

  assign log_w[0] = rd0_idx_i;
  assign log_w[1] = rd1_idx_i;
  assign log_w[2] = wr_idx_i;

  // all ports map with the pre-edge base
  for (genvar m = 0; m < int'(NMAP); m++) begin : g_map
    rrf_map #(.NREG(NREG), .ROT_LO(ROT_LO)) u_map (
      .log_i  (log_w[m]),
      .base_i (base_w),
      .phys_o (phys_w[m])
    );
  end

  for (genvar p = 0; p < int'(NRD); p++) begin : g_rdp
    assign rd_phys_w[p] = phys_w[p];
  end

  rrf_store #(.NREG(NREG), .WIDTH(WIDTH), .NRD(NRD)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (rd_phys_w),
    .rd_data_o (rd_data_w),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (phys_w[NMAP-1]),
    .wr_data_i (wr_data_i)
  );

  assign rd0_data_o = rd_data_w[0];
  assign rd1_data_o = rd_data_w[1];
  assign base_o     = base_w;
endmodule

// File: rtl/rrf_rotating_file_chk.sv
module rrf_rotating_file_chk #(
  parameter int unsigned NREG   = 128,
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned ROT_LO = 32,
  localparam int unsigned ROT_N  = NREG - ROT_LO,
  localparam int unsigned IDX_W  = $clog2(NREG),
  localparam int unsigned BASE_W = $clog2(ROT_N)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IDX_W-1:0]  rd0_idx_i,
  input logic [WIDTH-1:0]  rd0_data_o,
  input logic              wr_en_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic [WIDTH-1:0]  wr_data_i,
  input logic              rot_i,
  input logic              base_clr_i,
  input logic [BASE_W-1:0] base_o
);
  assert_base_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_o < BASE_W'(ROT_N));

  assert_rotate_dec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rot_i && !base_clr_i) |=>
      (base_o == (($past(base_o) == '0) ? BASE_W'(ROT_N - 1) : $past(base_o) - 1'b1)));

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_clr_i |=> (base_o == '0));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rot_i && !base_clr_i) |=> $stable(base_o));

  assert_direct_rb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && (wr_idx_i < IDX_W'(ROT_LO))) && (rd0_idx_i == $past(wr_idx_i)))
      |-> (rd0_data_o == $past(wr_data_i)));

  assert_same_base_rb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && !rot_i && !base_clr_i) && (rd0_idx_i == $past(wr_idx_i)))
      |-> (rd0_data_o == $past(wr_data_i)));

  assert_rot_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && rot_i && !base_clr_i && (wr_idx_i >= IDX_W'(ROT_LO))
           && (wr_idx_i < IDX_W'(NREG - 1)))
     && (rd0_idx_i == IDX_W'($past(wr_idx_i) + 1'b1)))
      |-> (rd0_data_o == $past(wr_data_i)));
endmodule

bind rrf_rotating_file rrf_rotating_file_chk #(
  .NREG(NREG), .WIDTH(WIDTH), .ROT_LO(ROT_LO)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd0_idx_i  (rd0_idx_i),
  .rd0_data_o (rd0_data_o),
  .wr_en_i    (wr_en_i),
  .wr_idx_i   (wr_idx_i),
  .wr_data_i  (wr_data_i),
  .rot_i      (rot_i),
  .base_clr_i (base_clr_i),
  .base_o     (base_o)
);

// File: tb/rrf_rotating_file_bench.sv
`timescale 1ns/1ps
module rrf_rotating_file_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  rd0_idx_i = '0, rd1_idx_i = '0, wr_idx_i = '0;
  logic [63:0] rd0_data_o, rd1_data_o, wr_data_i = '0;
  logic        wr_en_i = 1'b0, rot_i = 1'b0, base_clr_i = 1'b0;
  logic [6:0]  base_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [63:0] model [128];
  int mbase = 0;

  always #10 clk_i = ~clk_i;

  rrf_rotating_file u_rrf_rotating_file (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd0_idx_i(rd0_idx_i), .rd0_data_o(rd0_data_o),
    .rd1_idx_i(rd1_idx_i), .rd1_data_o(rd1_data_o),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .rot_i(rot_i), .base_clr_i(base_clr_i), .base_o(base_o)
  );

  function automatic int phys(int s, int b);
    if (s < 32) return s;
    return 32 + ((s - 32 + b) % 96);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle from a negedge: drive, compare before the edge, advance model
  task automatic cyc(bit we, int wi, logic [63:0] wd, bit rot, bit clr, int r0, int r1);
    wr_en_i = we; wr_idx_i = 7'(wi); wr_data_i = wd;
    rot_i = rot; base_clr_i = clr;
    rd0_idx_i = 7'(r0); rd1_idx_i = 7'(r1);
    #5;
    chk("R3 rd0", rd0_data_o, model[phys(r0, mbase)]);
    chk("R9 rd1", rd1_data_o, model[phys(r1, mbase)]);
    chk("R10 base", 64'(base_o), 64'(mbase));
    @(posedge clk_i);
    if (we) model[phys(wi, mbase)] = wd;
    if (clr) mbase = 0;
    else if (rot) mbase = (mbase == 0) ? 95 : mbase - 1;
    @(negedge clk_i);
  endtask

  task automatic peek(string req, int idx, logic [63:0] exp);
    wr_en_i = 1'b0; rot_i = 1'b0; base_clr_i = 1'b0;
    rd0_idx_i = 7'(idx);
    #1;
    chk(req, rd0_data_o, exp);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = '0;
    #35 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 base", 64'(base_o), 64'd0);
    peek("R1 reg0", 0, 64'd0);
    peek("R1 reg127", 127, 64'd0);

    // R2 direct region unaffected by base
    cyc(1, 5, 64'hA5A5, 0, 0, 0, 0);
    for (int k = 0; k < 7; k++) cyc(0, 0, 0, 1, 0, 5, 40);
    peek("R2 direct", 5, 64'hA5A5);
    chk("R4 base after 7", 64'(base_o), 64'd89);

    // R4 wrap 0 -> 95
    cyc(0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0);
    chk("R4 wrap", 64'(base_o), 64'd95);

    // R5 latency as specifier difference
    cyc(1, 40, 64'hB0B0, 0, 0, 40, 0);
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 1, 0, 0, 0);
    peek("R5 s+3", 43, 64'hB0B0);
    cyc(1, 127, 64'hC0C0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0);
    peek("R5 wrap 127->32", 32, 64'hC0C0);

    // R6 write with rotate uses old base
    cyc(1, 50, 64'hD0D0, 1, 0, 0, 0);
    peek("R6 old base", 51, 64'hD0D0);

    // R7 clear beats rotate
    cyc(0, 0, 0, 1, 1, 0, 0);
    chk("R7 clear priority", 64'(base_o), 64'd0);

    // R8 disabled write
    cyc(0, 60, 64'hDEAD, 0, 0, 0, 0);
    peek("R8 no write", 60, model[phys(60, mbase)]);

    // R9 read during write returns old value
    cyc(1, 7, 64'h1111, 0, 0, 7, 7);
    wr_en_i = 1'b1; wr_idx_i = 7'd7; wr_data_i = 64'h2222; rd0_idx_i = 7'd7;
    #1 chk("R9 old before edge", rd0_data_o, 64'h1111);
    @(posedge clk_i); model[7] = 64'h2222;
    @(negedge clk_i);
    peek("R9 new after edge", 7, 64'h2222);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      cyc(1'($urandom_range(0, 1)), int'($urandom_range(0, 127)),
          {$urandom, $urandom}, 1'($urandom_range(0, 2) == 0),
          1'($urandom_range(0, 60) == 0),
          int'($urandom_range(0, 127)), int'($urandom_range(0, 127)));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule